// File: doc/BRIEF.md
# Two-Finger RAKE Despreading Decoder

This block recovers one data bit per remote transmitter from a group of eight 4-bit chip samples that all arrive in the same clock cycle. Each transmitter has its own 8-chip spreading code. The channel has a direct path and a reflection one chip later. For each code the block therefore correlates the samples twice. The first finger uses the code as it is. The second finger uses the code rotated by one chip. The two correlations are then merged with fixed maximum-ratio weights, and the sign of the merged value is the decided bit.

The weights are unsigned fixed-point constants with four fractional bits, worked out offline from the channel profile. A parameter picks one of two ways to build the fingers. One form computes each finger correlation on its own. The other form adds up the chips where the code and its rotated copy agree, adds up separately the chips where they differ, and derives both finger values from those two partial sums, which needs fewer adders. The whole group is resolved in one clock: the decision and the soft metric are registered at the edge that samples the input.

Top module: `rake_two_finger_decoder`

## Requirements
- R1: While reset is held and after it is released, out_valid, out_bits and out_metric are all zero until the first valid group is accepted.
- R2: Sample j occupies in_samples[4j+3:4j] and is unsigned. In the direct finger, chip j adds sample j when bit j of the link's code is 0 and subtracts it when that bit is 1.
- R3: The delayed finger uses the code rotated by one chip. Chip j takes code bit j-1, and chip 0 takes code bit 7 of the same code.
- R4: The metric equals 16·lead + 10·lag exactly (weights 1.0 and 0.625 with four fractional bits), as a 16-bit two's-complement value, with no overflow for any input.
- R5: The decided bit is the sign bit of the metric. A metric of exactly zero decides 0.
- R6: Results for a group offered with in_valid high appear at the next rising edge, and out_valid equals in_valid delayed by one cycle.
- R7: While in_valid is low, out_bits and out_metric keep their last values, whatever is on in_samples.
- R8: Each link is decoded with its own code. The default codes are 0x0F, 0x33 and 0x55 for links 0, 1 and 2, where bit j is the bit for chip j.
- R9: The partial-sum form and the per-finger form give identical metrics and identical decisions on every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks in_samples as holding a chip group |
| in_samples | input | 32 | Eight unsigned 4-bit chip samples, chip j at bits [4j+3:4j] |
| out_valid | output | 1 | A new decision set was registered at the last edge |
| out_bits | output | 3 | Decided bit per link, link l at bit l |
| out_metric | output | 48 | Signed 16-bit combined metric per link, link l at bits [16l+15:16l] |

## Verification
In every cycle the direct finger and the delayed finger feed the same combine, so their contributions land on one sum together. The interesting cases are the ones where the two fingers pull in opposite directions or cancel each other out. The bench provokes these in several ways: it sweeps one chip at a time through all sixteen levels, including chip 0, whose delayed weight comes from the wrapped last code bit. It also drives flat groups whose correlations cancel to an exact zero, applies extreme groups, and runs a long pseudo-random stream. Each outcome is judged against metrics computed arithmetically from the codes, and both finger variants are checked at the same time.

// File: rtl/rake_pkg.sv
// Package: shared width arithmetic for the two-finger despreading decoder.
// Assumes unsigned samples and unsigned weights.
package rake_pkg;

    // Signed width that holds a full correlation of CHIPS unsigned samples.
    function automatic int corr_width(input int sample_w, input int chips);
        return sample_w + $clog2(chips) + 1;
    endfunction

    // Signed width of the weighted sum of two correlations.
    function automatic int metric_width(input int corr_w, input int weight_w);
        return corr_w + weight_w + 2;
    endfunction

    // Largest magnitude a single correlation can reach.
    function automatic int peak_corr(input int sample_w, input int chips);
        return chips * ((1 << sample_w) - 1);
    endfunction

endpackage

// File: rtl/rake_finger_direct.sv
// Module: rake_finger_direct
// Computes the lead-finger correlation against CODE and the lag-finger
// correlation against CODE rotated by one chip, each with its own adder chain.
// Assumes: code bit 1 negates a chip; lag chip 0 reuses the last code bit.
module rake_finger_direct #(
    parameter int SAMPLE_W = 4,
    parameter int CHIPS    = 8,
    parameter int CORR_W   = 8,
    parameter int PEAK     = 120,
    parameter logic [CHIPS-1:0] CODE = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CHIPS*SAMPLE_W-1:0]    samples,
    output logic signed [CORR_W-1:0]     corr_lead,
    output logic signed [CORR_W-1:0]     corr_lag
);

    localparam logic [CHIPS-1:0] LAG_CODE = {CODE[CHIPS-2:0], CODE[CHIPS-1]};

    logic signed [CORR_W-1:0] mag [CHIPS];

    // Zero-extend each chip sample into the signed correlation width.
    for (genvar j = 0; j < CHIPS; j++) begin : g_mag
        assign mag[j] = {{(CORR_W-SAMPLE_W){1'b0}}, samples[j*SAMPLE_W +: SAMPLE_W]};
    end

    // Accumulate both fingers chip by chip with signs taken from the codes.
    always_comb begin
        corr_lead = '0;
        corr_lag  = '0;
        for (int j = 0; j < CHIPS; j++) begin
            corr_lead = CODE[j]     ? corr_lead - mag[j] : corr_lead + mag[j];
            corr_lag  = LAG_CODE[j] ? corr_lag  - mag[j] : corr_lag  + mag[j];
        end
    end

    assert_lead_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_lead <= PEAK) && (corr_lead >= -PEAK));
    assert_lag_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_lag <= PEAK) && (corr_lag >= -PEAK));

endmodule

// File: rtl/rake_finger_shared.sv
// Module: rake_finger_shared
// Reduced-adder form of the two fingers. One partial sum covers the chips
// where CODE and its one-chip rotation agree, the other covers the chips where
// they differ. Then lead = agree + differ and lag = agree - differ.
// Assumes the same sign and rotation conventions as rake_finger_direct.
module rake_finger_shared #(
    parameter int SAMPLE_W = 4,
    parameter int CHIPS    = 8,
    parameter int CORR_W   = 8,
    parameter int PEAK     = 120,
    parameter logic [CHIPS-1:0] CODE = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CHIPS*SAMPLE_W-1:0]    samples,
    output logic signed [CORR_W-1:0]     corr_lead,
    output logic signed [CORR_W-1:0]     corr_lag
);

    localparam logic [CHIPS-1:0] LAG_CODE = {CODE[CHIPS-2:0], CODE[CHIPS-1]};
    localparam logic [CHIPS-1:0] AGREE    = ~(CODE ^ LAG_CODE);

    logic signed [CORR_W-1:0] mag [CHIPS];
    logic signed [CORR_W-1:0] sum_agree;
    logic signed [CORR_W-1:0] sum_differ;

    // Zero-extend each chip sample into the signed correlation width.
    for (genvar j = 0; j < CHIPS; j++) begin : g_mag
        assign mag[j] = {{(CORR_W-SAMPLE_W){1'b0}}, samples[j*SAMPLE_W +: SAMPLE_W]};
    end

    // Split the signed chips into the agreeing and the differing partial sums.
    always_comb begin
        sum_agree  = '0;
        sum_differ = '0;
        for (int j = 0; j < CHIPS; j++) begin
            if (AGREE[j])
                sum_agree  = CODE[j] ? sum_agree  - mag[j] : sum_agree  + mag[j];
            else
                sum_differ = CODE[j] ? sum_differ - mag[j] : sum_differ + mag[j];
        end
    end

    // Rebuild both finger values from the two shared partial sums.
    always_comb begin
        corr_lead = sum_agree + sum_differ;
        corr_lag  = sum_agree - sum_differ;
    end

    assert_partial_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_agree <= PEAK) && (sum_agree >= -PEAK)
        && (sum_differ <= PEAK) && (sum_differ >= -PEAK));

endmodule

// File: rtl/rake_mrc_combine.sv
// Module: rake_mrc_combine
// Weights the lead and lag correlations with fixed unsigned constants and
// adds them. The sign bit of the sum is the decision.
// Assumes the weights fit in WEIGHT_W bits and the metric width has room
// for the full sum.
module rake_mrc_combine #(
    parameter int CORR_W   = 8,
    parameter int WEIGHT_W = 6,
    parameter int METRIC_W = 16,
    parameter int G_LEAD   = 16,
    parameter int G_LAG    = 10,
    parameter int PEAK     = 120
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic signed [CORR_W-1:0]      corr_lead,
    input  logic signed [CORR_W-1:0]      corr_lag,
    output logic signed [METRIC_W-1:0]    metric,
    output logic                          decision
);

    localparam logic signed [WEIGHT_W:0] W_LEAD = (WEIGHT_W+1)'(G_LEAD);
    localparam logic signed [WEIGHT_W:0] W_LAG  = (WEIGHT_W+1)'(G_LAG);
    localparam int BOUND = (G_LEAD + G_LAG) * PEAK;

    logic signed [METRIC_W-1:0] prod_lead;
    logic signed [METRIC_W-1:0] prod_lag;

    // Scale each finger by its weight in the full metric width.
    always_comb begin
        prod_lead = METRIC_W'(corr_lead) * METRIC_W'(W_LEAD);
        prod_lag  = METRIC_W'(corr_lag)  * METRIC_W'(W_LAG);
    end

    // Sum the weighted fingers and take the sign as the decided bit.
    always_comb begin
        metric   = prod_lead + prod_lag;
        decision = metric[METRIC_W-1];
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (metric <= BOUND) && (metric >= -BOUND));

endmodule

// File: rtl/rake_two_finger_decoder.sv
// Module: rake_two_finger_decoder (top)
// For each link: two fingers (direct code and one-chip-rotated code),
// a fixed-weight combine, and sign decision, all in one clock. Results are
// registered and held while no group is offered.
// Assumes chip-aligned sample groups; SHARED_SUMS selects the partial-sum form.
module rake_two_finger_decoder #(
    parameter int SAMPLE_W    = 4,
    parameter int CHIPS       = 8,
    parameter int LINKS       = 3,
    parameter int WEIGHT_W    = 6,
    parameter int G_LEAD      = 16,
    parameter int G_LAG       = 10,
    parameter bit SHARED_SUMS = 1'b1,
    parameter logic [LINKS*CHIPS-1:0] CODES = 24'h55330F
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  in_valid,
    input  logic [CHIPS*SAMPLE_W-1:0]             in_samples,
    output logic                                  out_valid,
    output logic [LINKS-1:0]                      out_bits,
    output logic [LINKS*rake_pkg::metric_width(rake_pkg::corr_width(SAMPLE_W, CHIPS), WEIGHT_W)-1:0] out_metric
);

    localparam int CORR_W   = rake_pkg::corr_width(SAMPLE_W, CHIPS);
    localparam int METRIC_W = rake_pkg::metric_width(CORR_W, WEIGHT_W);
    localparam int PEAK     = rake_pkg::peak_corr(SAMPLE_W, CHIPS);

    logic [LINKS-1:0]          bits_next;
    logic [LINKS*METRIC_W-1:0] metric_next;

    for (genvar l = 0; l < LINKS; l++) begin : g_link
        logic signed [CORR_W-1:0]   c_lead;
        logic signed [CORR_W-1:0]   c_lag;
        logic signed [METRIC_W-1:0] m;
        logic                       d;

        if (SHARED_SUMS) begin : g_shared
            rake_finger_shared #(
                .SAMPLE_W(SAMPLE_W), .CHIPS(CHIPS), .CORR_W(CORR_W), .PEAK(PEAK),
                .CODE(CODES[l*CHIPS +: CHIPS])
            ) u_fingers (
                .clk(clk), .rst_n(rst_n), .samples(in_samples),
                .corr_lead(c_lead), .corr_lag(c_lag)
            );
        end else begin : g_direct
            rake_finger_direct #(
                .SAMPLE_W(SAMPLE_W), .CHIPS(CHIPS), .CORR_W(CORR_W), .PEAK(PEAK),
                .CODE(CODES[l*CHIPS +: CHIPS])
            ) u_fingers (
                .clk(clk), .rst_n(rst_n), .samples(in_samples),
                .corr_lead(c_lead), .corr_lag(c_lag)
            );
        end

        rake_mrc_combine #(
            .CORR_W(CORR_W), .WEIGHT_W(WEIGHT_W), .METRIC_W(METRIC_W),
            .G_LEAD(G_LEAD), .G_LAG(G_LAG), .PEAK(PEAK)
        ) u_combine (
            .clk(clk), .rst_n(rst_n), .corr_lead(c_lead), .corr_lag(c_lag),
            .metric(m), .decision(d)
        );

        assign metric_next[l*METRIC_W +: METRIC_W] = m;
        assign bits_next[l] = d;
    end

    // Register the decisions of an offered group; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_bits   <= '0;
            out_metric <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_bits   <= bits_next;
                out_metric <= metric_next;
            end
        end
    end

    assert_valid_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> ($stable(out_bits) && $stable(out_metric)));

    assert_zero_tie_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_samples == '0)) |=> ((out_bits == '0) && (out_metric == '0)));

endmodule

// File: tb/rake_two_finger_decoder_test.sv
module rake_two_finger_decoder_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] TB_CODES = 24'h55330F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_samples = '0;
    logic        v_s, v_d;
    logic [2:0]  b_s, b_d;
    logic [47:0] m_s, m_d;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [31:0] last_vec = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rake_two_finger_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
        .out_valid(v_s), .out_bits(b_s), .out_metric(m_s)
    );

    rake_two_finger_decoder #(.SHARED_SUMS(1'b0)) uut_direct (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
        .out_valid(v_d), .out_bits(b_d), .out_metric(m_d)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Correlation from the requirements: bit 1 negates; lag chip j uses bit j-1 (wrapping).
    function automatic int exp_corr(input int link, input bit lag, input logic [31:0] s);
        int acc = 0;
        for (int j = 0; j < 8; j++) begin
            int d = int'(s[4*j +: 4]);
            bit cb = lag ? TB_CODES[link*8 + ((j + 7) % 8)] : TB_CODES[link*8 + j];
            acc += cb ? -d : d;
        end
        return acc;
    endfunction

    task automatic check_outputs(input logic [31:0] s, input string req);
        for (int l = 0; l < 3; l++) begin
            int em = 16*exp_corr(l, 1'b0, s) + 10*exp_corr(l, 1'b1, s);
            int eb = (em < 0) ? 1 : 0;
            int as_m = int'($signed(m_s[l*16 +: 16]));
            int ad_m = int'($signed(m_d[l*16 +: 16]));
            chk(as_m == em, req, $sformatf("shared metric link%0d", l), as_m, em);
            chk(int'(b_s[l]) == eb, "R5", $sformatf("shared bit link%0d", l), int'(b_s[l]), eb);
            chk(ad_m == as_m, "R9", $sformatf("direct vs shared metric link%0d", l), ad_m, as_m);
            chk(b_d[l] == b_s[l], "R9", $sformatf("direct vs shared bit link%0d", l), int'(b_d[l]), int'(b_s[l]));
        end
    endtask

    task automatic apply(input logic [31:0] s, input string req);
        in_valid   = 1'b1;
        in_samples = s;
        @(negedge clk);
        chk(v_s == 1'b1 && v_d == 1'b1, "R6", "out_valid one cycle after group", int'(v_s), 1);
        check_outputs(s, req);
        last_vec = s;
    endtask

    initial begin
        logic [31:0] lf = 32'hACE1_2468;
        repeat (3) @(negedge clk);
        chk(v_s == 1'b0 && b_s == '0 && m_s == '0, "R1", "state in reset", int'(m_s[15:0]), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(v_s == 1'b0 && b_s == '0 && m_s == '0 && v_d == 1'b0, "R1", "state after reset",
            int'(v_s), 0);

        // R3: chip 0 alone exercises the wrapped lag bit; R2: each chip swept alone.
        apply(32'h0000_000F, "R3");
        for (int j = 0; j < 8; j++)
            for (int v = 0; v < 16; v++)
                apply(32'(v) << (4*j), "R2");

        // R5: flat groups make every link's fingers cancel to an exact zero.
        for (int v = 0; v < 16; v++)
            apply({8{4'(v)}}, "R5");

        // R4: extreme groups per link code (all on code-0 chips, then all on code-1 chips).
        for (int l = 0; l < 3; l++) begin
            logic [31:0] hi = '0;
            for (int j = 0; j < 8; j++)
                if (!TB_CODES[l*8 + j]) hi[4*j +: 4] = 4'hF;
            apply(hi, "R4");
            apply(~hi, "R4");
        end
        apply(32'hFFFF_FFFF, "R4");

        // R8: pseudo-random stream, each link judged against its own code.
        for (int n = 0; n < 4000; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            apply(lf, "R8");
        end

        // R7: idle cycles with changing samples leave the results untouched.
        for (int n = 0; n < 4; n++) begin
            in_valid   = 1'b0;
            in_samples = 32'h9E37_79B9 + 32'(n);
            @(negedge clk);
            chk(v_s == 1'b0, "R7", "out_valid low while idle", int'(v_s), 0);
            check_outputs(last_vec, "R7");
        end
        apply(32'h1234_5678, "R6");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL R6 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule